// File: doc/BRIEF.md
# ADC Register Front End

This block is the digital register interface of a successive-approximation converter inside a microcontroller. A small CPU bus (2-bit address, read strobe, write strobe, 8-bit write data, combinational read data) reaches three byte registers. The first is a control/status byte with the completion flag, clock-rate bit, power bit and channel field. The second is a high data byte. The third is a low data byte that also holds the slow-rate bit and the amplifier-zero bit. The block turns the CPU clock into a single-cycle converter clock enable and issues conversion start pulses while powered. It captures a 10-bit result when the converter port reports completion and keeps the completion flag.

The converter itself lies outside the block and is reached only through `conv_start`, `conv_done` and `conv_result`. The result port behaves as a valid-only stream. `conv_done` is the valid qualifier, and the block is always ready, so there is no back-pressure. A new result overwrites the captured one whether or not software has read it. Control pins (`adc_power`, `amp_cal`, `chan_sel`, `adc_clk_en`) are plain levels or pulses.

Top module: `adc_regif`

## Requirements
- R1: After reset, reads of address 0 (control/status), 1 (high data) and 2 (low data) all return 0x00, and `adc_power`, `amp_cal`, `chan_sel` and `conv_start` are 0.
- R2: The control/status byte at address 0 reads {flag, rate-bit, power, 0, 0, channel[2:0]}. A write stores bit 6 as the rate bit, bit 5 as the power bit and bits 2:0 as the channel. Written values of bits 7 and 4:3 are ignored. `adc_power` follows the stored power bit.
- R3: `chan_sel` presents the stored channel field unchanged from the cycle after the write (codes 000 to 110 select inputs 0 to 6).
- R4: The low data byte at address 2 reads {0,0,0, amp-zero, slow, 0, result[1:0]}. A write stores bit 4 as amp-zero (driven on `amp_cal`) and bit 3 as slow. Other written bits are ignored.
- R5: Address 1 reads result[9:2]. Writes to address 1 (and to the unused address 3, which reads 0x00) change nothing.
- R6: A free-running 2-bit counter, cleared by reset, produces `adc_clk_en`. With slow=1 the enable is high when the counter is 3 (one cycle in four), whatever the rate bit. With slow=0 and rate bit 1 it is high every cycle. With slow=0 and rate bit 0 it is high when the counter is odd (one cycle in two).
- R7: `conv_done` while the power bit is 1 captures `conv_result` into both data bytes and sets the flag in the next cycle. A further result while the flag is set overwrites the data, and the flag stays set.
- R8: A read strobe on address 1 clears the flag in the next cycle. If a capturing `conv_done` falls in the same cycle, the flag stays set.
- R9: While the power bit is 0, `conv_start` stays low and `conv_done` is ignored: no capture and no flag.
- R10: `conv_start` is a one-cycle pulse issued only in a cycle where `adc_clk_en` is high. It is issued at the first enable after a write that turns power on, and at the first enable after each completed conversion.
- R11: A control/status write with power 1 abandons any conversion in progress, and a new start follows at the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe (clears the flag on address 1) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Converter result valid |
| conv_result | input | 10 | Converter result |
| adc_clk_en | output | 1 | Converter clock enable |
| adc_power | output | 1 | Converter and amplifier power |
| amp_cal | output | 1 | Ties the amplifier input to 0 V |
| chan_sel | output | 3 | Selected analog input |

## Verification
The hardest situations to reach from the ports are coincidences: a clearing read of the high byte in the very cycle that a result arrives, and a control write that lands while a conversion is still pending, so a stale completion can arrive after the restart. Directed steps place a read and a `conv_done` in the same cycle and a control write between a start and its completion. The random phase drives `conv_done` from a bench converter with random latency, mixed with random reads, writes and power toggles. This lets such collisions recur under all three clock rates.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int DATA_W = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 3;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 2;
  localparam int LO_W   = RES_W - DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DHI  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DLO  = 2'd2;

  typedef enum logic [1:0] {RATE_DIV2, RATE_FULL, RATE_DIV4} rate_e;
  typedef enum logic [1:0] {SQ_OFF, SQ_ARM, SQ_BUSY} seq_e;

  function automatic rate_e rate_of(input logic slow, input logic fast);
    if (slow)      return RATE_DIV4;
    else if (fast) return RATE_FULL;
    else           return RATE_DIV2;
  endfunction
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_regif_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate,
  output logic  tick
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (rate)
      RATE_FULL: tick = 1'b1;
      RATE_DIV2: tick = cnt_q[0];
      RATE_DIV4: tick = &cnt_q[1:0];
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_regif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic power,
  input  logic restart,
  input  logic restart_on,
  input  logic tick,
  input  logic done,
  output logic start
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (restart) begin
      st_d = restart_on ? SQ_ARM : SQ_OFF;
    end else if (!power) begin
      st_d = SQ_OFF;
    end else begin
      case (st_q)
        SQ_ARM:  if (tick) st_d = SQ_BUSY;
        SQ_BUSY: if (done) st_d = SQ_ARM;
        default: st_d = SQ_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_OFF;
    else        st_q <= st_d;
  end

  assign start = (st_q == SQ_ARM) && tick && power;
endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_regif_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int CW = CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap,
  input  logic [RW-1:0]     result,
  output logic              fast,
  output logic              power,
  output logic              slow,
  output logic              azero,
  output logic [CW-1:0]     chan,
  output logic              flag,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int LW = RW - DATA_W;

  logic [RW-1:0] res_q;
  logic          dlo_wr, hi_rd;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign dlo_wr  = wr_en && (addr == A_DLO);
  assign hi_rd   = rd_en && (addr == A_DHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast  <= 1'b0;
      power <= 1'b0;
      chan  <= '0;
    end else if (ctrl_wr) begin
      fast  <= wdata[6];
      power <= wdata[5];
      chan  <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow  <= 1'b0;
      azero <= 1'b0;
    end else if (dlo_wr) begin
      slow  <= wdata[3];
      azero <= wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res_q <= '0;
    else if (cap) res_q <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (cap)    flag <= 1'b1;
    else if (hi_rd)  flag <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {flag, fast, power, 2'b00, chan};
      A_DHI:   rdata = res_q[RW-1 -: DATA_W];
      A_DLO:   rdata = {3'b000, azero, slow, 1'b0, res_q[LW-1:0]};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              adc_clk_en,
  output logic              adc_power,
  output logic              amp_cal,
  output logic [CH_W-1:0]   chan_sel
);
  logic fast, slow, ctrl_wr, eoc_flag, cap;

  assign cap = conv_done && adc_power;

  adc_regfile #(.RW(RES_W), .CW(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cap(cap), .result(conv_result), .fast(fast),
    .power(adc_power), .slow(slow), .azero(amp_cal), .chan(chan_sel),
    .flag(eoc_flag), .ctrl_wr(ctrl_wr), .rdata(rdata)
  );

  adc_clkdiv #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .rate(rate_of(slow, fast)), .tick(adc_clk_en)
  );

  adc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .power(adc_power), .restart(ctrl_wr),
    .restart_on(wdata[5]), .tick(adc_clk_en), .done(conv_done),
    .start(conv_start)
  );
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk
  import adc_regif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              conv_done,
  input logic              conv_start,
  input logic              adc_clk_en,
  input logic              adc_power,
  input logic [CH_W-1:0]   chan_sel,
  input logic              eoc
);
  // R9
  start_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> adc_power);

  // R10
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> adc_clk_en);

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !(wr_en && addr == A_CTRL)) |=> !conv_start);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && adc_power) |=> eoc);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DHI && !(conv_done && adc_power)) |=> !eoc);

  // R3
  chan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> chan_sel == $past(wdata[CH_W-1:0]));

  // R2
  power_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> adc_power == $past(wdata[5]));
endmodule

bind adc_regif adc_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .conv_done(conv_done), .conv_start(conv_start),
  .adc_clk_en(adc_clk_en), .adc_power(adc_power), .chan_sel(chan_sel),
  .eoc(eoc_flag)
);

// File: tb/tb_adc_regif.sv
module tb_adc_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, conv_done = 1'b0;
  logic [7:0] wdata = '0;
  logic [9:0] conv_result = '0;
  logic [7:0] rdata;
  logic       conv_start, adc_clk_en, adc_power, amp_cal;
  logic [2:0] chan_sel;

  always #5 clk = ~clk;

  adc_regif dut (.*);

  int checks = 0, fails = 0;
  int unsigned m_cnt = 0;
  bit m_fast, m_pwr, m_slow, m_az, m_eoc, m_armed;
  bit [2:0] m_ch;
  bit [9:0] m_res;
  bit last_start;
  bit cv_busy; int cv_left; bit [9:0] cv_val;

  function automatic bit exp_en();
    if (m_slow) return (m_cnt % 4) == 3;
    if (m_fast) return 1'b1;
    return (m_cnt % 2) == 1;
  endfunction

  function automatic bit [7:0] exp_rd(input bit [1:0] a);
    case (a)
      2'd0: return {m_eoc, m_fast, m_pwr, 2'b00, m_ch};
      2'd1: return m_res[9:2];
      2'd2: return {3'b000, m_az, m_slow, 1'b0, m_res[1:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic peek(input bit [1:0] a, output bit [7:0] v);
    addr = a; rd_en = 1'b0; wr_en = 1'b0; conv_done = 1'b0;
    #1 v = rdata;
  endtask

  task automatic step(input bit w, input bit r, input bit [1:0] a,
                      input bit [7:0] d, input bit dn, input bit [9:0] rv);
    bit st_e, cap, arm_n;
    wr_en = w; rd_en = r; addr = a; wdata = d; conv_done = dn; conv_result = rv;
    #1;
    chk("R6 clock enable", adc_clk_en, exp_en());
    st_e = m_pwr && m_armed && exp_en();
    chk("R10 start pulse", conv_start, st_e);
    chk("R3 channel output", chan_sel, m_ch);
    chk("R4 amp zero output", amp_cal, m_az);
    chk("R2 power output", adc_power, m_pwr);
    case (a)
      2'd0: chk("R2 control read", rdata, exp_rd(a));
      2'd1: chk("R5 high data read", rdata, exp_rd(a));
      2'd2: chk("R4 low data read", rdata, exp_rd(a));
      default: chk("R5 unused address read", rdata, exp_rd(a));
    endcase
    last_start = conv_start;
    @(posedge clk);
    cap = dn && m_pwr;
    if (w && a == 2'd0) arm_n = d[5];
    else if (!m_pwr)    arm_n = 1'b0;
    else if (st_e)      arm_n = 1'b0;
    else if (dn)        arm_n = 1'b1;
    else                arm_n = m_armed;
    m_armed = arm_n;
    if (cap) begin m_eoc = 1'b1; m_res = rv; end
    else if (r && a == 2'd1) m_eoc = 1'b0;
    if (w && a == 2'd0) begin m_fast = d[6]; m_pwr = d[5]; m_ch = d[2:0]; end
    if (w && a == 2'd2) begin m_az = d[4]; m_slow = d[3]; end
    m_cnt++;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 8'h00, 0, 10'h0); endtask

  task automatic auto_step(input bit w, input bit r, input bit [1:0] a, input bit [7:0] d);
    bit dn;
    dn = cv_busy && cv_left == 0;
    step(w, r, a, d, dn, cv_val);
    if (dn) cv_busy = 0;
    else if (cv_busy) cv_left--;
    if (last_start) begin
      cv_busy = 1; cv_left = $urandom_range(0, 5); cv_val = 10'($urandom);
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit [7:0] v;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(0, v); chk("R1 reset control", v, 0);
    peek(1, v); chk("R1 reset high data", v, 0);
    peek(2, v); chk("R1 reset low data", v, 0);
    chk("R1 reset start", conv_start, 0);
    chk("R1 reset power", adc_power, 0);
    // R9 result ignored while off
    step(0, 0, 0, 0, 1, 10'h3FF);
    peek(1, v); chk("R9 no capture when off", v, 0);
    peek(0, v); chk("R9 no flag when off", v[7], 0);
    // power on, channel 5
    step(1, 0, 0, 8'h25, 0, 0);
    chk("R3 channel 5", chan_sel, 3'd5);
    n = 0;
    repeat (3) begin if (conv_start) n++; idle(); end
    chk("R10 start after power on", n, 1);
    step(0, 0, 0, 0, 1, 10'h2B6);
    peek(1, v); chk("R7 high byte captured", v, 8'hAD);
    peek(2, v); chk("R7 low bits captured", v, 8'h02);
    peek(0, v); chk("R7 flag set", v[7], 1);
    step(0, 0, 0, 0, 1, 10'h155);
    peek(1, v); chk("R7 overwrite data", v, 8'h55);
    peek(0, v); chk("R7 flag stays set", v[7], 1);
    // R8 set beats clear, then clear
    step(0, 1, 1, 0, 1, 10'h0F0);
    peek(0, v); chk("R8 set wins over read", v[7], 1);
    step(0, 1, 1, 0, 0, 0);
    peek(0, v); chk("R8 read clears flag", v[7], 0);
    // R5 high data write ignored
    step(1, 0, 1, 8'hFF, 0, 0);
    peek(1, v); chk("R5 write to high data ignored", v, 8'h3C);
    // R2 reserved and flag bits ignored on write
    step(1, 0, 0, 8'hFF, 0, 0);
    peek(0, v); chk("R2 control readback", v, 8'h67);
    // R4 low data write
    step(1, 0, 2, 8'hFF, 0, 0);
    peek(2, v); chk("R4 low data readback", v, 8'h18);
    chk("R4 amp zero driven", amp_cal, 1);
    // R6 rates over 8 cycles
    n = 0; repeat (8) begin if (adc_clk_en) n++; idle(); end
    chk("R6 slow rate count", n, 2);
    step(1, 0, 2, 8'h00, 0, 0);
    n = 0; repeat (8) begin if (adc_clk_en) n++; idle(); end
    chk("R6 full rate count", n, 8);
    step(1, 0, 0, 8'h23, 0, 0);
    n = 0; repeat (8) begin if (adc_clk_en) n++; idle(); end
    chk("R6 half rate count", n, 4);
    // R11 restart during a pending conversion
    step(1, 0, 0, 8'h22, 0, 0);
    n = 0; repeat (4) begin if (conv_start) n++; idle(); end
    chk("R11 restart issues start", n, 1);
    // R9 power off: no starts
    step(1, 0, 0, 8'h00, 0, 0);
    n = 0; repeat (6) begin if (conv_start) n++; idle(); end
    chk("R9 no start while off", n, 0);
    // random phase
    cv_busy = 0;
    for (int i = 0; i < 4000; i++) begin
      int op;
      bit [7:0] d;
      op = $urandom_range(0, 19);
      d = 8'($urandom);
      if (op < 2) begin
        d[5] = ($urandom_range(0, 4) != 0);
        auto_step(1, 0, 0, d);
      end else if (op == 2) auto_step(1, 0, 2, d);
      else if (op == 3) auto_step(1, 0, 2'($urandom_range(1, 3)), d);
      else if (op < 8) auto_step(0, 1, 2'($urandom_range(0, 3)), d);
      else auto_step(0, 0, 2'($urandom_range(0, 3)), d);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule